// File: doc/BRIEF.md
# Configurable Reset Request Controller

This block gathers reset requests raised across the chip and turns each one into a reset of a programmable kind. Four sources carry their own two-bit type field: a software request, a watchdog overflow, a core reset instruction and a memory parity error. Three debug control inputs and a dedicated debug reset input map to fixed kinds. A request whose type field is zero is dropped.

Once a request is taken, the block asserts the reset lines for the chosen kind. It runs a down-counter loaded from a programmable reload value, which cannot be set below a floor. While that counter runs it may pull the external reset pin low. After the counter phase the pin is released. If the pin is still held low from outside, the reset is stretched until the synchronised pin level reads high again. A status vector records which sources caused the latest accepted reset.

Top module: `rst_req_ctrl`

## Requirements
- R1: After reset the reset lines, `busy`, `pinDrive` and `lastSrc` are all low, and the reload value equals `RELOAD_MIN`.
- R2: A pulse on `swReq`, `wdtOvf`, `cpuSrst` or `parErr` produces the reset kind held in that source's own type field. The kinds are 00 none, 01 internal application (`rstIntApp` only), 10 application (`rstIntApp` and `rstApp`) and 11 debug (all three lines). A request with type 00 leaves `busy` and `lastSrc` unchanged.
- R3: `dbgRstFn`, or `dbgCtl1` and `dbgCtl3` together, request a debug reset. `dbgCtl2` requests an internal application reset and `dbgCtl3` an application reset. `dbgCtl1` alone requests nothing.
- R4: When several requests arrive in one cycle, the widest kind among them is applied.
- R5: While `busy` is high, new requests are ignored: the reset lines and `lastSrc` stay unchanged until the sequence ends.
- R6: With `pinOutEn` low, `busy` and the reset lines stay high for reload+1 cycles, starting the cycle after the request.
- R7: A write through `reloadWe` stores `max(reloadVal, RELOAD_MIN)`.
- R8: `pinDrive` is high exactly during the reload+1 counter cycles when `pinOutEn` is high, and is never high otherwise.
- R9: With `pinOutEn` high, the reset continues after the counter phase until the pin, passed through a two-flop synchroniser, reads high. `busy` falls three cycles after the pin first rises, once the counter phase has ended.
- R10: On acceptance, `lastSrc` takes a mask of the requesting sources that have a nonzero kind. The bit order is 0 software, 1 watchdog, 2 CPU, 3 parity, 4 debug reset, 5 `dbgCtl2`, 6 `dbgCtl3`. A `statusClr` pulse clears the mask, and an acceptance in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swReq | input | 1 | Software reset request pulse |
| swType | input | 2 | Reset kind for software requests |
| wdtOvf | input | 1 | Watchdog overflow request pulse |
| wdtType | input | 2 | Reset kind for watchdog requests |
| cpuSrst | input | 1 | Core reset-instruction request pulse |
| cpuType | input | 2 | Reset kind for core requests |
| parErr | input | 1 | Memory parity error request pulse |
| parType | input | 2 | Reset kind for parity requests |
| dbgRstFn | input | 1 | Dedicated debug reset request |
| dbgCtl1 | input | 1 | Debug control bit 1 |
| dbgCtl2 | input | 1 | Debug control bit 2 |
| dbgCtl3 | input | 1 | Debug control bit 3 |
| reloadWe | input | 1 | Reload value write strobe |
| reloadVal | input | CNT_W | Reload value to write |
| statusClr | input | 1 | Clears the source status vector |
| pinOutEn | input | 1 | External pin enabled as reset output |
| pinIn | input | 1 | Sampled external reset pin level |
| rstIntApp | output | 1 | Internal application reset line |
| rstApp | output | 1 | Application reset line |
| rstDbg | output | 1 | Debug reset line |
| pinDrive | output | 1 | Drive the external pin low |
| busy | output | 1 | Reset sequence in progress |
| lastSrc | output | 7 | Sources of the latest accepted reset |

## Verification
Two functions can land on the same clock edge. The first is a software clear of the status vector together with the acceptance of a new request. The second is several sources of different kinds requesting at once. The bench provokes both with directed cases and through random stimulus that can set `statusClr` and any mix of sources in the request cycle. It then expects `lastSrc` to hold the new source mask rather than zero, and expects the reset lines to show the widest kind among the requests.

// File: rtl/rst_req_pkg.sv
package rst_req_pkg;

  typedef enum logic [1:0] {
    RT_NONE   = 2'b00,
    RT_INTAPP = 2'b01,
    RT_APP    = 2'b10,
    RT_DBG    = 2'b11
  } rstTypeT;

  localparam int NUM_SRC = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // take the widest pending request
    logic countEn;  // counter phase running
    logic active;   // reset sequence in progress
  } ctrlStrbT;

endpackage

// File: rtl/rst_req_dp.sv
module rst_req_dp
  import rst_req_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int RELOAD_MIN  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          reqVec,
  input  logic [NUM_SRC-1:0][1:0]     srcType,
  input  logic                        reloadWe,
  input  logic [CNT_W-1:0]            reloadVal,
  input  logic                        statusClr,
  input  logic                        pinIn,
  input  ctrlStrbT                    strb,
  output logic                        anyReq,
  output logic                        cntZero,
  output logic                        pinHigh,
  output logic                        rstIntApp,
  output logic                        rstApp,
  output logic                        rstDbg,
  output logic [NUM_SRC-1:0]          lastSrc
);

  localparam logic [CNT_W-1:0] RELOAD_FLOOR = CNT_W'(RELOAD_MIN);

  logic [NUM_SRC-1:0][1:0] maskedType;
  logic [NUM_SRC-1:0]      reqMask;
  rstTypeT                 reqType;
  rstTypeT                 typeReg;
  logic [CNT_W-1:0]        reloadReg;
  logic [CNT_W-1:0]        cnt;
  logic [SYNC_STAGES-1:0]  syncQ;

  // per-source qualification
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign maskedType[g] = reqVec[g] ? srcType[g] : 2'b00;
    assign reqMask[g]    = reqVec[g] && (srcType[g] != 2'b00);
  end

  // widest kind among simultaneous requests
  always_comb begin
    reqType = RT_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (maskedType[i] > reqType) reqType = rstTypeT'(maskedType[i]);
    end
  end

  assign anyReq = (reqType != RT_NONE);

  // reload register with floor clamp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadReg <= RELOAD_FLOOR;
    else if (reloadWe) reloadReg <= (reloadVal < RELOAD_FLOOR) ? RELOAD_FLOOR : reloadVal;
  end

  // reset counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strb.accept) cnt <= reloadReg;
    else if (strb.countEn && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // applied reset kind
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) typeReg <= RT_NONE;
    else if (strb.accept) typeReg <= reqType;
  end

  assign rstIntApp = strb.active && (typeReg != RT_NONE);
  assign rstApp    = strb.active && (typeReg == RT_APP || typeReg == RT_DBG);
  assign rstDbg    = strb.active && (typeReg == RT_DBG);

  // source status, acceptance wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastSrc <= '0;
    else if (strb.accept) lastSrc <= reqMask;
    else if (statusClr) lastSrc <= '0;
  end

  // pin level synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  assign pinHigh = syncQ[SYNC_STAGES-1];

  a_r5_type_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strb.active |=> $stable(typeReg));

  a_r5_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !statusClr) |=> $stable(lastSrc));

  a_r7_reload_floor: assert property (@(posedge clk) disable iff (!rstN)
    reloadWe |=> (reloadReg >= RELOAD_FLOOR));

  a_r6_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.accept && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rst_req_fsm.sv
module rst_req_fsm
  import rst_req_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyReq,
  input  logic     cntZero,
  input  logic     pinHigh,
  input  logic     pinOutEn,
  output ctrlStrbT strb,
  output logic     busy,
  output logic     pinDrive
);

  typedef enum logic [1:0] {ST_IDLE, ST_CNT, ST_EXT} stateT;

  stateT state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (anyReq) stateNxt = ST_CNT;
      ST_CNT:  if (cntZero) stateNxt = pinOutEn ? ST_EXT : ST_IDLE;
      ST_EXT:  if (pinHigh) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end

  assign strb.accept  = (state == ST_IDLE) && anyReq;
  assign strb.countEn = (state == ST_CNT);
  assign strb.active  = (state != ST_IDLE);
  assign busy         = strb.active;
  assign pinDrive     = (state == ST_CNT) && pinOutEn;

  a_r9_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXT && !pinHigh) |=> busy);

  a_r6_count_stays: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CNT && !cntZero) |=> (state == ST_CNT));

  a_r5_no_reaccept: assert property (@(posedge clk) disable iff (!rstN)
    (busy && anyReq && !cntZero) |=> busy);

endmodule

// File: rtl/rst_req_ctrl.sv
module rst_req_ctrl
  import rst_req_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int RELOAD_MIN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReq,
  input  logic [1:0]       swType,
  input  logic             wdtOvf,
  input  logic [1:0]       wdtType,
  input  logic             cpuSrst,
  input  logic [1:0]       cpuType,
  input  logic             parErr,
  input  logic [1:0]       parType,
  input  logic             dbgRstFn,
  input  logic             dbgCtl1,
  input  logic             dbgCtl2,
  input  logic             dbgCtl3,
  input  logic             reloadWe,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             statusClr,
  input  logic             pinOutEn,
  input  logic             pinIn,
  output logic             rstIntApp,
  output logic             rstApp,
  output logic             rstDbg,
  output logic             pinDrive,
  output logic             busy,
  output logic [6:0]       lastSrc
);

  logic [NUM_SRC-1:0]      reqVec;
  logic [NUM_SRC-1:0][1:0] srcType;
  ctrlStrbT                strb;
  logic                    anyReq, cntZero, pinHigh;

  assign reqVec  = {dbgCtl3, dbgCtl2, dbgRstFn | (dbgCtl1 & dbgCtl3),
                    parErr, cpuSrst, wdtOvf, swReq};
  assign srcType = {RT_APP, RT_INTAPP, RT_DBG, parType, cpuType, wdtType, swType};

  rst_req_dp #(
    .CNT_W(CNT_W), .RELOAD_MIN(RELOAD_MIN), .SYNC_STAGES(2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .srcType(srcType),
    .reloadWe(reloadWe), .reloadVal(reloadVal), .statusClr(statusClr),
    .pinIn(pinIn), .strb(strb), .anyReq(anyReq), .cntZero(cntZero),
    .pinHigh(pinHigh), .rstIntApp(rstIntApp), .rstApp(rstApp),
    .rstDbg(rstDbg), .lastSrc(lastSrc)
  );

  rst_req_fsm fsm_i (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .cntZero(cntZero),
    .pinHigh(pinHigh), .pinOutEn(pinOutEn), .strb(strb),
    .busy(busy), .pinDrive(pinDrive)
  );

endmodule

// File: tb/rst_req_ctrl_tb_top.sv
module rst_req_ctrl_tb_top;

  localparam int CNT_W = 8;
  localparam int RMIN  = 4;

  logic clk = 0, rstN = 0;
  logic swReq = 0, wdtOvf = 0, cpuSrst = 0, parErr = 0;
  logic [1:0] swType = 0, wdtType = 0, cpuType = 0, parType = 0;
  logic dbgRstFn = 0, dbgCtl1 = 0, dbgCtl2 = 0, dbgCtl3 = 0;
  logic reloadWe = 0, statusClr = 0, pinOutEn = 0, extHold = 0;
  logic [CNT_W-1:0] reloadVal = 0;
  logic pinIn, rstIntApp, rstApp, rstDbg, pinDrive, busy;
  logic [6:0] lastSrc;

  int checks = 0, errors = 0, curR = RMIN;
  logic [6:0] expStatus = 0;
  bit done = 0;

  assign pinIn = !(pinDrive || extHold);

  always #10 clk = ~clk;

  rst_req_ctrl #(.CNT_W(CNT_W), .RELOAD_MIN(RMIN)) dut_i (
    .clk(clk), .rstN(rstN), .swReq(swReq), .swType(swType), .wdtOvf(wdtOvf),
    .wdtType(wdtType), .cpuSrst(cpuSrst), .cpuType(cpuType), .parErr(parErr),
    .parType(parType), .dbgRstFn(dbgRstFn), .dbgCtl1(dbgCtl1), .dbgCtl2(dbgCtl2),
    .dbgCtl3(dbgCtl3), .reloadWe(reloadWe), .reloadVal(reloadVal),
    .statusClr(statusClr), .pinOutEn(pinOutEn), .pinIn(pinIn),
    .rstIntApp(rstIntApp), .rstApp(rstApp), .rstDbg(rstDbg),
    .pinDrive(pinDrive), .busy(busy), .lastSrc(lastSrc)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int lineCode(int t);
    return (t >= 1 ? 1 : 0) | (t >= 2 ? 2 : 0) | (t == 3 ? 4 : 0);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic writeReload(int v);
    @(negedge clk);
    reloadWe = 1; reloadVal = CNT_W'(v);
    @(negedge clk);
    reloadWe = 0;
    curR = (v < RMIN) ? RMIN : v;
  endtask

  // one request cycle followed by the whole sequence
  task automatic doSeq(string tag, logic s, logic [1:0] st, logic w, logic [1:0] wt,
                       logic c, logic [1:0] ct, logic p, logic [1:0] pt,
                       logic fn, logic b1, logic b2, logic b3,
                       logic oe, int m, logic clr, logic inject);
    int eType, n, bad;
    logic [6:0] eMask;
    eMask = 0; eType = 0;
    if (s && st != 0) begin eMask[0] = 1; eType = maxi(eType, st); end
    if (w && wt != 0) begin eMask[1] = 1; eType = maxi(eType, wt); end
    if (c && ct != 0) begin eMask[2] = 1; eType = maxi(eType, ct); end
    if (p && pt != 0) begin eMask[3] = 1; eType = maxi(eType, pt); end
    if (fn || (b1 && b3)) begin eMask[4] = 1; eType = 3; end
    if (b2) begin eMask[5] = 1; eType = maxi(eType, 1); end
    if (b3) begin eMask[6] = 1; eType = maxi(eType, 2); end
    @(negedge clk);
    swReq = s; swType = st; wdtOvf = w; wdtType = wt; cpuSrst = c; cpuType = ct;
    parErr = p; parType = pt; dbgRstFn = fn; dbgCtl1 = b1; dbgCtl2 = b2; dbgCtl3 = b3;
    statusClr = clr; pinOutEn = oe; extHold = oe;
    @(negedge clk);
    swReq = 0; wdtOvf = 0; cpuSrst = 0; parErr = 0;
    dbgRstFn = 0; dbgCtl1 = 0; dbgCtl2 = 0; dbgCtl3 = 0; statusClr = 0;
    if (eType == 0) begin
      if (clr) expStatus = 0;
      check({tag, " R2 ignored busy"}, busy, 0);
      check({tag, " R10 status"}, lastSrc, expStatus);
      extHold = 0;
      return;
    end
    expStatus = eMask;
    check({tag, " lines"}, {rstDbg, rstApp, rstIntApp}, lineCode(eType));
    check({tag, " R10 status"}, lastSrc, eMask);
    n = 0; bad = 0;
    while (busy && n < 1000) begin
      if (n == m) extHold = 0;
      if (pinDrive != (oe && n <= curR)) bad++;
      if ({rstDbg, rstApp, rstIntApp} != 3'(lineCode(eType))) bad++;
      if (inject && n == 1) begin
        swReq = 1; swType = 3; dbgCtl2 = 1;
      end
      if (inject && n == 2) begin
        swReq = 0; dbgCtl2 = 0;
      end
      n++;
      @(negedge clk);
    end
    swReq = 0; dbgCtl2 = 0; extHold = 0;
    check({tag, " R8 R5 pin/lines during sequence"}, bad, 0);
    check({tag, oe ? " R9 extended length" : " R6 length"}, n,
          oe ? maxi(curR + 1, m) + 3 : curR + 1);
    if (inject) check({tag, " R5 status kept"}, lastSrc, eMask);
    check({tag, " lines off"}, {rstDbg, rstApp, rstIntApp}, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 lines", {rstDbg, rstApp, rstIntApp}, 0);
    check("R1 pinDrive", pinDrive, 0);
    check("R1 lastSrc", lastSrc, 0);

    // R1 default reload, R2 per-source kinds
    doSeq("R2 sw int", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    doSeq("R2 wdt app", 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    doSeq("R2 cpu dbg", 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    doSeq("R2 par none", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    doSeq("R2 par app", 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 debug sources
    doSeq("R3 fn", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    doSeq("R3 bit1 alone", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    doSeq("R3 bit1&3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
    doSeq("R3 bit2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    doSeq("R3 bit3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R4 widest of simultaneous
    doSeq("R4 mix", 1, 1, 0, 0, 1, 2, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R5 requests during busy ignored
    doSeq("R5 inject", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R7 clamp and R6 length
    writeReload(0);
    doSeq("R7 clamp", 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    writeReload(11);
    doSeq("R6 reload11", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8 R9 pin behaviour
    doSeq("R9 no hold", 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    doSeq("R9 long hold", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 25, 0, 0);
    // R10 clear alone and clear with acceptance
    @(negedge clk); statusClr = 1;
    @(negedge clk); statusClr = 0; expStatus = 0;
    check("R10 clear", lastSrc, 0);
    doSeq("R10 clr+accept", 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 3) == 0) writeReload($urandom_range(0, 20));
      doSeq("RND",
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 1)), $urandom_range(0, 30),
            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
    end
    finishRun();
  end

endmodule